// File: doc/BRIEF.md
# Sense-Before-Write Controller for a Differential Two-Resistor Array

This block sequences every access to a byte-wide array built from differential cell pairs, where each stored bit lives in two resistive elements switched in opposite directions. A request arrives on a write enable or a read enable with an 8-bit address and 8-bit input data. The controller selects the addressed block switch and cell column, drives the per-bit wordline and bitline levels, strobes the sense amplifier for one cycle, and returns the sensed byte on its data output.

A write never pulses blindly. It first reads the addressed byte, compares it with the input data bit by bit, and drives a write pulse only on bits that differ. Bits that already hold the wanted value keep their bitline at the half level. When all bits match, the access finishes with no pulse at all. This limits wear and the disturbance of neighbouring cells. The drive levels are given as 2-bit codes; the analog drivers, the sense amplifier and the cells themselves sit outside the block.

Top module: `sbw_rram_ctrl`

## Requirements
- R1: After reset, busy, done, saEn, gwlEn, blkSw and cellSel are 0, dataOut is 0, every bitline code is half (2'd2) and every wordline code is ground (2'd0).
- R2: While an access is in progress, from the cycle after acceptance until the cycle before done, blkSw is one-hot with bit addr[7:2] set and cellSel is one-hot with bit addr[1:0] set.
- R3: The second cycle after acceptance is the sense cycle. In it, saEn is high for exactly one cycle, every wordline-A code is read (2'd1), every wordline-B code is ground (2'd0) and every bitline code is read (2'd1), meaning the bitline is released to the sense node.
- R4: The sensed byte appears on dataOut in the cycle after the sense cycle and stays unchanged until the next access senses.
- R5: A write request reads first. When the sensed byte equals the input data, no pulse is issued and done is raised in the fourth cycle after acceptance.
- R6: During a write pulse, a bit that differs and must become 1 gets wordline-A and wordline-B code write (2'd3) and bitline code ground (2'd0).
- R7: During a write pulse, a bit that differs and must become 0 gets wordline codes ground (2'd0) and bitline code write (2'd3). A bit that already matches gets wordline codes ground and bitline code half (2'd2).
- R8: A write pulse lasts exactly PULSE_CYC cycles (default 2), with gwlEn high, and done follows in the next cycle.
- R9: Outside an access, all bitline codes are half (2'd2) and all wordline codes are ground.
- R10: A request with both wrEn and rdEn high is a read: no pulse, and done is raised in the third cycle after acceptance.
- R11: Requests presented while busy is high are ignored; the address in use does not change, and no access follows.
- R12: busy is high from the cycle after acceptance through the done cycle, done is high for one cycle, and busy is low in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write request |
| rdEn | input | 1 | Read request (wins over wrEn) |
| addr | input | 8 | Byte address: [7:2] block, [1:0] cell |
| dataIn | input | 8 | Write data |
| saOut | input | 8 | Sense amplifier outputs, one per bit |
| dataOut | output | 8 | Registered read data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access marker |
| saEn | output | 1 | Sense amplifier enable strobe |
| gwlEn | output | 1 | Global wordline drive enable |
| blkSw | output | 64 | One-hot local wordline switch enables |
| cellSel | output | 4 | One-hot cell column within the local wordline |
| wlaLvl | output | 16 | Wordline-A level code per bit, bit i at [2i+1:2i] |
| wlbLvl | output | 16 | Wordline-B level code per bit |
| blLvl | output | 16 | Bitline level code per bit |

## Verification
After a request is driven and clocked in, selection is due in the first cycle, the sense strobe in the second, and read data in the third. The compare cycle follows for writes, then PULSE_CYC pulse cycles or none, then done. The bench walks each access one falling edge at a time and samples each result in exactly the cycle above. Comparing every bit's level codes in every pulse cycle confirms both the mask and the pulse length. The array model in the bench decodes the one-hot selects on its own, so later reads show whether each write landed at the right address.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

  typedef enum logic [1:0] {
    LV_GND   = 2'd0,
    LV_READ  = 2'd1,
    LV_HALF  = 2'd2,
    LV_WRITE = 2'd3
  } lvl_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SENSE,
    ST_CMP,
    ST_WRITE,
    ST_DONE
  } st_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capReq;   // latch address and data
    logic capRead;  // latch sensed byte
    logic capMask;  // latch per-bit difference mask
    logic selOn;    // block switch and column select active
    logic sense;    // read bias and sense strobe
    logic pulse;    // write bias
  } strb_t;

endpackage

// File: rtl/sbw_ctrl_fsm.sv
module sbw_ctrl_fsm
  import sbw_pkg::*;
#(
  parameter int PULSE_CYC = 2
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  wrEn,
  input  logic  rdEn,
  input  logic  diff,
  output strb_t strb,
  output logic  busy,
  output logic  done
);

  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  st_e state, stateNxt;
  logic isWrQ;
  logic [CNT_W-1:0] pulseCnt;
  logic accept;

  assign accept = (state == ST_IDLE) && (wrEn || rdEn);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:  if (accept) stateNxt = ST_PRE;
      ST_PRE:   stateNxt = ST_SENSE;
      ST_SENSE: stateNxt = isWrQ ? ST_CMP : ST_DONE;
      ST_CMP:   stateNxt = diff ? ST_WRITE : ST_DONE;
      ST_WRITE: if (pulseCnt == CNT_W'(PULSE_CYC - 1)) stateNxt = ST_DONE;
      ST_DONE:  stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      isWrQ    <= 1'b0;
      pulseCnt <= '0;
    end else begin
      state <= stateNxt;
      if (accept) isWrQ <= wrEn && !rdEn;
      if (state == ST_WRITE) pulseCnt <= pulseCnt + 1'b1;
      else                   pulseCnt <= '0;
    end
  end

  always_comb begin
    strb.capReq  = accept;
    strb.capRead = (state == ST_SENSE);
    strb.capMask = (state == ST_CMP);
    strb.selOn   = (state == ST_PRE) || (state == ST_SENSE) ||
                   (state == ST_CMP) || (state == ST_WRITE);
    strb.sense   = (state == ST_SENSE);
    strb.pulse   = (state == ST_WRITE);
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  // R3
  sense_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.sense |=> !strb.sense);

  // R12
  done_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R8
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WRITE) |-> (pulseCnt < CNT_W'(PULSE_CYC)));

  // R11
  no_reaccept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

endmodule

// File: rtl/sbw_datapath.sv
module sbw_datapath
  import sbw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int CELL_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  strb_t               strb,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic [DATA_W-1:0]   saOut,
  output logic                diff,
  output logic [DATA_W-1:0]   dataOut,
  output logic                saEn,
  output logic                gwlEn,
  output logic [(1<<(ADDR_W-CELL_W))-1:0] blkSw,
  output logic [(1<<CELL_W)-1:0]          cellSel,
  output logic [2*DATA_W-1:0] wlaLvl,
  output logic [2*DATA_W-1:0] wlbLvl,
  output logic [2*DATA_W-1:0] blLvl
);

  localparam int BLK_W    = ADDR_W - CELL_W;
  localparam int NUM_BLK  = 1 << BLK_W;
  localparam int NUM_CELL = 1 << CELL_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dinQ, rdQ, maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dinQ  <= '0;
      rdQ   <= '0;
      maskQ <= '0;
    end else begin
      if (strb.capReq) begin
        addrQ <= addr;
        dinQ  <= dataIn;
      end
      if (strb.capRead) rdQ   <= saOut;
      if (strb.capMask) maskQ <= rdQ ^ dinQ;
    end
  end

  assign diff    = |(rdQ ^ dinQ);
  assign dataOut = rdQ;
  assign saEn    = strb.sense;
  assign gwlEn   = strb.sense || strb.pulse;

  always_comb begin
    blkSw   = '0;
    cellSel = '0;
    if (strb.selOn) begin
      blkSw   = NUM_BLK'(1)  << addrQ[ADDR_W-1:CELL_W];
      cellSel = NUM_CELL'(1) << addrQ[CELL_W-1:0];
    end
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    lvl_e wa, wb, bl;
    always_comb begin
      wa = LV_GND;
      wb = LV_GND;
      bl = LV_HALF;
      if (strb.sense) begin
        wa = LV_READ;
        bl = LV_READ;
      end else if (strb.pulse && maskQ[i]) begin
        if (dinQ[i]) begin
          wa = LV_WRITE;
          wb = LV_WRITE;
          bl = LV_GND;
        end else begin
          bl = LV_WRITE;
        end
      end
    end
    assign wlaLvl[2*i +: 2] = wa;
    assign wlbLvl[2*i +: 2] = wb;
    assign blLvl[2*i +: 2]  = bl;
  end

  // R2
  blk_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(blkSw) && $onehot0(cellSel));

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capRead |=> $stable(dataOut));

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.selOn |=> $stable(addrQ));

  // R7
  pulse_needs_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pulse |-> (maskQ != '0));

endmodule

// File: rtl/sbw_rram_ctrl.sv
module sbw_rram_ctrl
  import sbw_pkg::*;
#(
  parameter int PULSE_CYC = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [7:0]  addr,
  input  logic [7:0]  dataIn,
  input  logic [7:0]  saOut,
  output logic [7:0]  dataOut,
  output logic        busy,
  output logic        done,
  output logic        saEn,
  output logic        gwlEn,
  output logic [63:0] blkSw,
  output logic [3:0]  cellSel,
  output logic [15:0] wlaLvl,
  output logic [15:0] wlbLvl,
  output logic [15:0] blLvl
);

  strb_t strb;
  logic  diff;

  sbw_ctrl_fsm #(.PULSE_CYC(PULSE_CYC)) fsm_i (
    .clk  (clk),
    .rstN (rstN),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .diff (diff),
    .strb (strb),
    .busy (busy),
    .done (done)
  );

  sbw_datapath #(.DATA_W(8), .ADDR_W(8), .CELL_W(2)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .addr    (addr),
    .dataIn  (dataIn),
    .saOut   (saOut),
    .diff    (diff),
    .dataOut (dataOut),
    .saEn    (saEn),
    .gwlEn   (gwlEn),
    .blkSw   (blkSw),
    .cellSel (cellSel),
    .wlaLvl  (wlaLvl),
    .wlbLvl  (wlbLvl),
    .blLvl   (blLvl)
  );

endmodule

// File: tb/sbw_rram_ctrl_tb.sv
module sbw_rram_ctrl_tb_top;

  localparam int PERIOD = 10;
  localparam int PULSE  = 2;
  localparam int NVEC   = 10;

  // {we, re, addr, din, expected read, pulse expected}
  typedef struct packed {
    logic       we;
    logic       re;
    logic [7:0] a;
    logic [7:0] d;
    logic [7:0] rd;
    logic       pl;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 8'h00, 8'h00, 8'h5A, 1'b0},
    '{1'b1, 1'b0, 8'h00, 8'hA5, 8'h5A, 1'b1},
    '{1'b0, 1'b1, 8'h00, 8'h00, 8'hA5, 1'b0},
    '{1'b1, 1'b0, 8'h00, 8'hA5, 8'hA5, 1'b0},
    '{1'b1, 1'b0, 8'hFF, 8'hA5, 8'hA5, 1'b0},
    '{1'b1, 1'b0, 8'h47, 8'h0F, 8'h1D, 1'b1},
    '{1'b1, 1'b1, 8'h47, 8'h00, 8'h0F, 1'b0},
    '{1'b0, 1'b1, 8'h83, 8'h00, 8'hD9, 1'b0},
    '{1'b1, 1'b0, 8'h83, 8'hD8, 8'hD9, 1'b1},
    '{1'b0, 1'b1, 8'h83, 8'h00, 8'hD8, 1'b0}
  };

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] addr = '0, dataIn = '0, saOut, dataOut;
  logic busy, done, saEn, gwlEn;
  logic [63:0] blkSw;
  logic [3:0] cellSel;
  logic [15:0] wlaLvl, wlbLvl, blLvl;

  int checks = 0, errors = 0;
  logic [7:0] mem [256];

  always #(PERIOD/2) clk = ~clk;

  sbw_rram_ctrl #(.PULSE_CYC(PULSE)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .dataIn(dataIn), .saOut(saOut), .dataOut(dataOut), .busy(busy),
    .done(done), .saEn(saEn), .gwlEn(gwlEn), .blkSw(blkSw),
    .cellSel(cellSel), .wlaLvl(wlaLvl), .wlbLvl(wlbLvl), .blLvl(blLvl)
  );

  // behavioural cell-pair array: decode the one-hot selects
  function automatic int selIdx();
    int b = -1, c = -1;
    for (int k = 0; k < 64; k++) if (blkSw[k]) b = k;
    for (int k = 0; k < 4; k++)  if (cellSel[k]) c = k;
    if (b < 0 || c < 0) return -1;
    return b * 4 + c;
  endfunction

  always_comb begin
    int ix;
    ix = selIdx();
    saOut = (saEn && ix >= 0) ? mem[ix] : 8'h00;
  end

  always @(posedge clk) begin
    int ix;
    ix = selIdx();
    if (gwlEn && ix >= 0) begin
      for (int i = 0; i < 8; i++) begin
        if (wlaLvl[2*i +: 2] == 2'd3 && blLvl[2*i +: 2] == 2'd0) mem[ix][i] <= 1'b1;
        if (wlaLvl[2*i +: 2] == 2'd0 && blLvl[2*i +: 2] == 2'd3) mem[ix][i] <= 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chkIdle(input string req);
    chk(blLvl == {8{2'd2}}, req, blLvl, {8{2'd2}});
    chk(wlaLvl == '0 && wlbLvl == '0, req, {wlaLvl, wlbLvl}, 0);
  endtask

  task automatic runAcc(input vec_t v);
    logic [7:0] mask;
    bit readType;
    readType = v.re;
    mask = v.rd ^ v.d;
    @(negedge clk);
    wrEn = v.we; rdEn = v.re; addr = v.a; dataIn = v.d;
    @(negedge clk);  // select cycle
    wrEn = 1'b0; rdEn = 1'b0;
    chk(busy == 1'b1, "R12 busy", busy, 1);
    chk(blkSw == (64'd1 << v.a[7:2]), "R2 blkSw", blkSw, 64'd1 << v.a[7:2]);
    chk(cellSel == (4'd1 << v.a[1:0]), "R2 cellSel", cellSel, 4'd1 << v.a[1:0]);
    chk(saEn == 1'b0, "R3 no early strobe", saEn, 0);
    @(negedge clk);  // sense cycle
    chk(saEn == 1'b1, "R3 strobe", saEn, 1);
    chk(wlaLvl == {8{2'd1}} && wlbLvl == '0 && blLvl == {8{2'd1}},
        "R3 read bias", {wlaLvl, wlbLvl, blLvl}, {16'h5555, 16'h0, 16'h5555});
    @(negedge clk);
    chk(dataOut == v.rd, "R4 dataOut", dataOut, v.rd);
    chk(saEn == 1'b0, "R3 strobe single", saEn, 0);
    if (readType) begin
      chk(done == 1'b1, "R10 read done", done, 1);
    end else begin
      chk(done == 1'b0, "R5 compare cycle", done, 0);
      @(negedge clk);
      if (v.pl) begin
        for (int k = 0; k < PULSE; k++) begin
          for (int i = 0; i < 8; i++) begin
            logic [5:0] act, exp;
            act = {wlaLvl[2*i +: 2], wlbLvl[2*i +: 2], blLvl[2*i +: 2]};
            if (!mask[i])     exp = {2'd0, 2'd0, 2'd2};
            else if (v.d[i])  exp = {2'd3, 2'd3, 2'd0};
            else              exp = {2'd0, 2'd0, 2'd3};
            chk(act == exp, v.d[i] && mask[i] ? "R6 set encoding" : "R7 encoding",
                act, exp);
          end
          chk(gwlEn == 1'b1 && done == 1'b0, "R8 pulse active", {gwlEn, done}, 2'b10);
          @(negedge clk);
        end
        chk(done == 1'b1, "R8 done after pulse", done, 1);
      end else begin
        chk(done == 1'b1, "R5 skip pulse", done, 1);
      end
    end
    chk(dataOut == v.rd, "R4 hold at done", dataOut, v.rd);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R12 release", {busy, done}, 0);
    chkIdle("R9 idle bias");
    chk(dataOut == v.rd, "R4 hold after", dataOut, v.rd);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, done, saEn, gwlEn} == 4'b0, "R1 flags", {busy, done, saEn, gwlEn}, 0);
    chk(blkSw == '0 && cellSel == '0, "R1 selects", {blkSw, cellSel}, 0);
    chk(dataOut == 8'h00, "R1 dataOut", dataOut, 0);
    chkIdle("R1 bias");
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("R9 idle after reset");

    for (int n = 0; n < NVEC; n++) runAcc(VECS[n]);

    // R11: request held through a busy access is ignored
    @(negedge clk);
    rdEn = 1'b1; addr = 8'h10;
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b1; addr = 8'h20; dataIn = 8'h00;
    chk(blkSw == (64'd1 << 4), "R11 select kept", blkSw, 64'd1 << 4);
    @(negedge clk);
    chk(blkSw == (64'd1 << 4) && cellSel == 4'd1, "R11 select stable",
        {blkSw, cellSel}, {64'd1 << 4, 4'd1});
    @(negedge clk);
    chk(done == 1'b1 && dataOut == 8'h4A, "R11 read result", {done, dataOut}, {1'b1, 8'h4A});
    wrEn = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R11 no new access", busy, 0);
    @(negedge clk);
    chk(busy == 1'b0, "R11 still idle", busy, 0);
    runAcc('{1'b0, 1'b1, 8'h20, 8'h00, 8'h7A, 1'b0});  // R11 target untouched

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule